// File: doc/BRIEF.md
# On-Chip Buffered Integer Matrix Multiplier

This engine forms the product C = A x B of two 64x64 matrices of 32-bit signed integers. A pulse on `start` makes it copy both operands from external memory into local buffers. Every external word is fetched exactly once. A is read row by row. B is also read row by row, but each word is written to its transposed position in the local store, so that column j of B sits as one row of that store. Each output element is therefore formed from one row of A and one row of the stored B.

Both operand stores are split into 64 banks along the reduction index, so all 64 terms of a dot product are available in a single cycle. The datapath has 64 multipliers and a registered adder tree. It finishes one C element per clock, in row-major order, and writes each result into an on-chip result store. Once all 4096 results are present, the engine writes C to external memory and pulses `done`.

The external side is one word-addressed request port. A request is accepted in a cycle where `mem_req` and `mem_gnt` are both high. Read data returns in request order, one word per cycle in which `mem_rvalid` is high. The three base addresses are inputs and must be held steady for the whole run.

Top module: `mm_engine`

## Requirements
- R1: After reset, and whenever no run is in progress, `mem_req` and `done` are low and no memory traffic is produced.
- R2: A run reads each word at `a_base + i*64 + k` (A element row i, column k) and at `b_base + k*64 + j` (B element row k, column j) exactly once, and touches no other read address. All 8192 read responses arrive before the first write request is raised.
- R3: Every C element equals the sum over k of A[i][k]*B[k][j], computed in 32-bit two's complement and wrapping modulo 2^32 with no saturation.
- R4: C is written to word address `c_base + i*64 + j` exactly once per element, in row-major order (j fastest). A request that is not granted holds its address, direction and data until it is granted.
- R5: Results emerge at one per clock after a fixed pipeline. The first write request is raised exactly 4104 cycles (4096 + 8) after the clock edge that samples the last read response.
- R6: B is used through its columns. When A is the identity matrix, C equals B exactly, including for a B that is not symmetric.
- R7: A `start` pulse while a run is in progress is ignored: it causes no extra read, no extra write and no second `done`.
- R8: `done` is high for exactly one cycle, namely the cycle right after the clock edge that accepts the last C write, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the engine is idle |
| a_base | input | ADDR_W | Word address of A[0][0] |
| b_base | input | ADDR_W | Word address of B[0][0] |
| c_base | input | ADDR_W | Word address of C[0][0] |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data valid, returned in request order |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Read data is due one cycle after a read is granted, and the bench's memory model supplies it at exactly that point. The first write must appear 4104 cycles after the edge that samples the final read response. The bench records the cycle number of that edge and compares it with the cycle in which the write request first becomes visible. Each write is compared at the moment it is granted, against the next expected element in a scoreboard queue. `done` is sampled in the single cycle after the final grant and must be low in every other cycle. All samples are taken on the falling edge, which is half a period away from the edges where the design updates.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_STORE,
    ST_FIN
  } mm_state_t;

endpackage

// File: rtl/mm_bank.sv
// One bank of an operand store: one write port, one registered read port.
module mm_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/mm_dot.sv
// One product stage, then a registered binary adder tree; latency 1 + log2(DIM).
module mm_dot #(
  parameter int DIM  = 64,
  parameter int W    = 32,
  localparam int LOG2 = $clog2(DIM),
  localparam int LAT  = LOG2 + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DIM-1:0][W-1:0] a_row,
  input  logic [DIM-1:0][W-1:0] b_row,
  output logic                  out_valid,
  output logic [W-1:0]          out_sum
);

  // Heap layout: leaves at DIM..2*DIM-1, root at 1.
  logic [W-1:0]   node [1:2*DIM-1];
  logic [LAT-1:0] vld_q;

  for (genvar k = 0; k < DIM; k++) begin : g_leaf
    always_ff @(posedge clk) begin
      if (in_valid) node[DIM+k] <= a_row[k] * b_row[k];
    end
  end

  for (genvar n = 1; n < DIM; n++) begin : g_sum
    always_ff @(posedge clk) begin
      node[n] <= node[2*n] + node[2*n+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  assign out_valid = vld_q[LAT-1];
  assign out_sum   = node[1];

endmodule

// File: rtl/mm_ctrl.sv
// Sequencer: load A and B, issue compute indices, collect results, write back C.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int DIM    = 64,
  parameter int ADDR_W = 32,
  localparam int LOG2  = $clog2(DIM),
  localparam int TOT_W = 2 * LOG2,
  localparam int CNT_W = TOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [ADDR_W-1:0] c_base,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic              res_valid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load_wr,
  output logic [TOT_W:0]    rsp_idx,
  output logic              issue,
  output logic [TOT_W-1:0]  idx,
  output logic [TOT_W-1:0]  res_idx,
  output logic              done
);

  localparam logic [CNT_W-1:0] TOT_C = CNT_W'(1) << TOT_W;
  localparam logic [CNT_W-1:0] ALL_C = CNT_W'(1) << (TOT_W + 1);

  mm_state_t        st_q, st_d;
  logic [CNT_W-1:0] req_q, req_d;
  logic [CNT_W-1:0] rsp_q, rsp_d;
  logic [CNT_W-1:0] res_q, res_d;

  always_comb begin
    st_d     = st_q;
    req_d    = req_q;
    rsp_d    = rsp_q;
    res_d    = res_q;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    issue    = 1'b0;
    done     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_LOAD;
          req_d = '0;
          rsp_d = '0;
          res_d = '0;
        end
      end
      ST_LOAD: begin
        if (req_q < ALL_C) begin
          mem_req  = 1'b1;
          mem_addr = (req_q[TOT_W] ? b_base : a_base) + ADDR_W'(req_q[TOT_W-1:0]);
          if (mem_gnt) req_d = req_q + 1'b1;
        end
        if (mem_rvalid) begin
          rsp_d = rsp_q + 1'b1;
          if (rsp_q == ALL_C - 1'b1) begin
            st_d  = ST_CALC;
            req_d = '0;
          end
        end
      end
      ST_CALC: begin
        if (req_q < TOT_C) begin
          issue = 1'b1;
          req_d = req_q + 1'b1;
        end
        if (res_valid) begin
          res_d = res_q + 1'b1;
          if (res_q == TOT_C - 1'b1) begin
            st_d  = ST_STORE;
            req_d = '0;
          end
        end
      end
      ST_STORE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = c_base + ADDR_W'(req_q[TOT_W-1:0]);
        if (mem_gnt) begin
          req_d = req_q + 1'b1;
          if (req_q == TOT_C - 1'b1) st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
      rsp_q <= '0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      rsp_q <= rsp_d;
      res_q <= res_d;
    end
  end

  assign load_wr = (st_q == ST_LOAD) && mem_rvalid;
  assign rsp_idx = rsp_q[TOT_W:0];
  assign idx     = req_q[TOT_W-1:0];
  assign res_idx = res_q[TOT_W-1:0];

endmodule

// File: rtl/mm_engine.sv
module mm_engine #(
  parameter int DIM    = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [ADDR_W-1:0] c_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done
);

  localparam int LOG2  = $clog2(DIM);
  localparam int TOT_W = 2 * LOG2;
  localparam int TOT   = DIM * DIM;

  logic              load_wr, issue, rd_vld, res_valid;
  logic [TOT_W:0]    rsp_idx;
  logic [TOT_W-1:0]  idx, res_idx;
  logic [DATA_W-1:0] dot_sum;
  logic [DIM-1:0][DATA_W-1:0] a_row, b_row;

  mm_ctrl #(.DIM(DIM), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n, .start, .a_base, .b_base, .c_base,
    .mem_gnt, .mem_rvalid, .res_valid,
    .mem_req, .mem_we, .mem_addr,
    .load_wr, .rsp_idx, .issue, .idx, .res_idx, .done
  );

  // Response index: bit TOT_W selects B; low field = column within the
  // external row, high field = external row number.
  logic            ph_b;
  logic [LOG2-1:0] rsp_lo, rsp_hi, rd_row, rd_col;
  assign ph_b   = rsp_idx[TOT_W];
  assign rsp_lo = rsp_idx[LOG2-1:0];
  assign rsp_hi = rsp_idx[TOT_W-1:LOG2];
  assign rd_row = idx[TOT_W-1:LOG2];
  assign rd_col = idx[LOG2-1:0];

  for (genvar k = 0; k < DIM; k++) begin : g_bank
    // A[i][k] -> bank k, entry i
    mm_bank #(.DEPTH(DIM), .W(DATA_W)) u_a (
      .clk,
      .we    (load_wr && !ph_b && (rsp_lo == LOG2'(k))),
      .waddr (rsp_hi),
      .wdata (mem_rdata),
      .re    (issue),
      .raddr (rd_row),
      .rdata (a_row[k])
    );
    // B[k][j] -> bank k, entry j (transposed placement)
    mm_bank #(.DEPTH(DIM), .W(DATA_W)) u_b (
      .clk,
      .we    (load_wr && ph_b && (rsp_hi == LOG2'(k))),
      .waddr (rsp_lo),
      .wdata (mem_rdata),
      .re    (issue),
      .raddr (rd_col),
      .rdata (b_row[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= issue;
  end

  mm_dot #(.DIM(DIM), .W(DATA_W)) u_dot (
    .clk, .rst_n,
    .in_valid  (rd_vld),
    .a_row, .b_row,
    .out_valid (res_valid),
    .out_sum   (dot_sum)
  );

  logic [DATA_W-1:0] cbuf [TOT];

  always_ff @(posedge clk) begin
    if (res_valid) cbuf[res_idx] <= dot_sum;
  end

  assign mem_wdata = cbuf[idx];

endmodule

// File: rtl/mm_engine_chk.sv
module mm_engine_chk #(
  parameter int DIM    = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_gnt,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] a_base,
  input logic [ADDR_W-1:0] b_base,
  input logic              done
);

  localparam int TOT   = DIM * DIM;
  localparam int CNT_W = $clog2(TOT) + 2;

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= '0;
    else if (done)       seen_q <= '0;
    else if (mem_rvalid) seen_q <= seen_q + 1'b1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && mem_we && mem_gnt));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata))));

  // R2
  wr_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (seen_q == CNT_W'(2 * TOT)));

  // R2
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ((mem_addr - a_base) < ADDR_W'(TOT) ||
                              (mem_addr - b_base) < ADDR_W'(TOT)));

endmodule

bind mm_engine mm_engine_chk #(.DIM(DIM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mm_engine_bench.sv
`timescale 1ns/1ps
module mm_engine_bench;

  localparam int DIM = 64;
  localparam int TOT = DIM * DIM;
  localparam int LAT = 8;

  logic        clk, rst_n, start;
  logic [31:0] a_base, b_base, c_base;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  mm_engine u_mm_engine (
    .clk, .rst_n, .start, .a_base, .b_base, .c_base,
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_gnt, .mem_rvalid, .mem_rdata, .done
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  longint cyc = 0;
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  typedef struct { logic [31:0] addr; logic [31:0] data; } exp_t;
  exp_t        expq[$];
  logic [31:0] mem [logic [31:0]];
  int          rd_hits [logic [31:0]];
  logic [31:0] am [DIM][DIM];
  logic [31:0] bm [DIM][DIM];

  bit          pend, first_wr, expect_done, run_done;
  logic [31:0] pend_a;
  int          rsp_total;
  longint      last_rsp_cyc;
  string       data_req = "R3";

  // Memory model and scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; pend = 1'b0;
    end else begin
      mem_rvalid = pend;
      if (pend) begin
        mem_rdata = mem.exists(pend_a) ? mem[pend_a] : 32'hdead_beef;
        rsp_total++;
        if (rsp_total == 2 * TOT) last_rsp_cyc = cyc + 1;
      end
      if (expect_done) begin
        chk(done === 1'b1, "R8", "done after last write", longint'(done), 1);
        expect_done = 1'b0;
        run_done = 1'b1;
      end else if (done !== 1'b0) begin
        chk(1'b0, "R8", "done outside its cycle", longint'(done), 0);
      end
      if (mem_req && mem_we && !first_wr) begin
        first_wr = 1'b1;
        chk(rsp_total == 2 * TOT, "R2", "responses before first write", rsp_total, 2 * TOT);
        chk(cyc - last_rsp_cyc == TOT + LAT, "R5", "first write delay",
            cyc - last_rsp_cyc, TOT + LAT);
      end
      mem_gnt = (cyc % 4) != 2;
      pend = 1'b0;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R4", "extra write", longint'(mem_addr), 0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(mem_addr == e.addr, "R4", "write address", longint'(mem_addr), longint'(e.addr));
            chk(mem_wdata == e.data, data_req, "C element", longint'(mem_wdata), longint'(e.data));
            if (expq.size() == 0) expect_done = 1'b1;
          end
        end else begin
          rd_hits[mem_addr] = rd_hits.exists(mem_addr) ? rd_hits[mem_addr] + 1 : 1;
          pend   = 1'b1;
          pend_a = mem_addr;
        end
      end
    end
  end

  task automatic run_job(input logic [31:0] ab, input logic [31:0] bb,
                         input logic [31:0] cb, input int kind, input bit poke);
    logic [31:0] seed = 32'h1234_5678 + kind;
    int bad = 0;
    int reqs = 0;
    for (int i = 0; i < DIM; i++) begin
      for (int k = 0; k < DIM; k++) begin
        case (kind)
          0: begin
            seed = seed * 32'd1664525 + 32'd1013904223; am[i][k] = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; bm[i][k] = seed;
          end
          1: begin
            am[i][k] = ((i + k) % 2 == 0) ? 32'h7fff_ffff : 32'h8000_0000;
            bm[i][k] = (k % 3 == 0) ? 32'hffff_ffff : 32'h7fff_fff3;
          end
          default: begin
            am[i][k] = (i == k) ? 32'd1 : 32'd0;
            bm[i][k] = 32'(i * 1000 + k);
          end
        endcase
      end
    end
    for (int i = 0; i < DIM; i++) begin
      for (int k = 0; k < DIM; k++) begin
        mem[ab + 32'(i * DIM + k)] = am[i][k];
        mem[bb + 32'(i * DIM + k)] = bm[i][k];
      end
    end
    for (int i = 0; i < DIM; i++) begin
      for (int j = 0; j < DIM; j++) begin
        exp_t e;
        logic [31:0] acc = '0;
        for (int k = 0; k < DIM; k++) acc += am[i][k] * bm[k][j];
        e.addr = cb + 32'(i * DIM + j);
        e.data = acc;
        expq.push_back(e);
      end
    end
    data_req = (kind == 2) ? "R6" : "R3";
    rd_hits.delete();
    rsp_total = 0; first_wr = 1'b0; run_done = 1'b0;
    @(negedge clk);
    a_base = ab; b_base = bb; c_base = cb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3000) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!run_done) @(negedge clk);
    for (int n = 0; n < TOT; n++) begin
      if (!rd_hits.exists(ab + 32'(n)) || rd_hits[ab + 32'(n)] != 1) bad++;
      if (!rd_hits.exists(bb + 32'(n)) || rd_hits[bb + 32'(n)] != 1) bad++;
    end
    chk(bad == 0 && rd_hits.num() == 2 * TOT, "R2", "single fetch of A and B",
        rd_hits.num(), 2 * TOT);
    chk(expq.size() == 0, "R4", "all C written", expq.size(), 0);
    repeat (40) @(negedge clk) if (mem_req) reqs++;
    chk(reqs == 0, poke ? "R7" : "R1", "idle after run", reqs, 0);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8", "watchdog, done never seen", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    a_base = '0; b_base = '0; c_base = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(mem_req === 1'b0, "R1", "mem_req after reset", longint'(mem_req), 0);
    chk(done === 1'b0, "R1", "done after reset", longint'(done), 0);
    run_job(32'h0000_1000, 32'h0000_3000, 32'h0000_8000, 0, 1'b1);  // R3, R7
    run_job(32'h0002_0000, 32'h0001_0000, 32'h0000_0000, 1, 1'b0);  // R3 wrap
    run_job(32'h0000_0000, 32'h0000_1000, 32'h0000_2000, 2, 1'b0);  // R6
    finish_up();
  end

endmodule